// File: doc/BRIEF.md
# Switching Activity Stress Generator

This block is a deliberately wasteful bank of flip-flops and counters for a programmable logic fabric. It produces switching activity that can be set and repeated, so that supply current and rail noise can be measured while the clock frequency is swept. Each mode gives a different current profile. In the checkerboard shift mode, neighbouring bits move in opposite directions, so the rising and falling loads cancel. In the synchronous toggle mode, every bit moves the same way on the same edge. The counter mode is a moderate and steady calibration load.

The mode is taken from a 2-bit select only while the synchronous reset is held. A mode change therefore needs a reinitialisation. While reset is held, nothing toggles, which gives a baseline. A clock enable freezes all state while the clock keeps running, so clock-network power can be measured apart from fabric power. An output enable decides whether the toggling bits reach the pins. A build option moves the upper half of the bank onto the falling clock edge. The parity output keeps all the logic observable, so none of it can be optimised away.

Top module: `sw_stress_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the bank is cleared, counter k is set to k, and the mode select is captured. After two such edges with `out_en` high, `pins` reads 0 and `parity` reads 0.
- R2: Mode 01 is checkerboard. On the first enabled cycle after reset, the bank loads bit i = 1 for even i and 0 for odd i (0x5555 for 16 bits). On each later enabled cycle, every bit takes its lower neighbour's old value and bit 0 takes its own inverse, so every bit inverts.
- R3: Mode 10 is synchronous toggle. All bits are driven from one shared line. From the cleared state, the first enabled cycle sets every bit to 1, and each later enabled cycle inverts every bit together.
- R4: Mode 11 is the counter array. Each enabled cycle adds 1 to every counter, modulo 2^CNTW. With `out_en` high, `pins` shows the low NBITS bits of counter 0.
- R5: While `clk_en` is low, no bank bit and no counter changes.
- R6: Mode 00 is idle. The bank stays zero and the counters keep their values.
- R7: Changing `mode` while `rst` is low has no effect until the next reset.
- R8: With `out_en` low, `pins` is all zero. With it high, `pins` shows the bank, or counter 0 in mode 11.
- R9: `parity` is the XOR of every bank bit and every counter bit.
- R10: With SPLIT set, the upper half of the bank updates on the falling edge that follows the rising edge which updates the lower half. Both halves act on the same sampled controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge for most state, falling edge for the upper half when SPLIT is set |
| rst | input | 1 | Synchronous reset, active high; also captures the mode |
| mode | input | 2 | 00 idle, 01 checkerboard, 10 synchronous toggle, 11 counters |
| clk_en | input | 1 | Global enable; low freezes all state |
| out_en | input | 1 | Drives the toggling bits onto `pins` |
| pins | output | NBITS | Bank or counter 0 value, zero when disabled |
| parity | output | 1 | XOR reduction of the bank and all counters |

## Verification
The case hardest to reach from the ports is the half-cycle gap between the two bank halves. Values sampled once per cycle, just before the rising edge, hide it completely. The bench samples one nanosecond after a rising edge in toggle mode, where only the lower half can have moved, and expects 0x00FF before the falling edge and 0xFFFF after it. In every mode sweep, the mode input is changed right after reset is released and the enables follow irregular patterns. This shows that the mode captured during reset is the one that governs, and that frozen cycles leave the state untouched.

// File: rtl/sw_stress_gen.sv
module sw_stress_gen #(
  parameter int NBITS = 16,
  parameter int NCNT  = 4,
  parameter int CNTW  = 32,
  parameter bit SPLIT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             clk_en,
  input  logic             out_en,
  output logic [NBITS-1:0] pins,
  output logic             parity
);
  localparam int NH = SPLIT ? 2 : 1;
  localparam int HW = NBITS / NH;
  localparam logic [1:0] M_CHK = 2'b01;
  localparam logic [1:0] M_TGL = 2'b10;
  localparam logic [1:0] M_CNT = 2'b11;

  function automatic logic [HW-1:0] alt_pat();
    logic [HW-1:0] r;
    for (int i = 0; i < HW; i++) r[i] = (i % 2 == 0);
    return r;
  endfunction
  localparam logic [HW-1:0] ALT = alt_pat();

  logic [1:0]           mode_q;
  logic                 rst_r, en_r;
  logic [NBITS-1:0]     bank;
  logic [NCNT*CNTW-1:0] cnt_flat;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= mode;
    rst_r <= rst;
    en_r  <= clk_en;
  end

  for (genvar h = 0; h < NH; h++) begin : g_seg
    localparam bit LATE = SPLIT && (h == 1);
    logic [HW-1:0] seg, seg_nx;
    logic          primed, primed_nx;
    logic          s_rst, s_en;
    assign s_rst = LATE ? rst_r : rst;
    assign s_en  = LATE ? en_r  : clk_en;

    always_comb begin
      seg_nx    = seg;
      primed_nx = primed;
      if (s_rst) begin
        seg_nx    = '0;
        primed_nx = 1'b0;
      end else if (s_en) begin
        case (mode_q)
          M_CHK: begin
            seg_nx    = primed ? {seg[HW-2:0], ~seg[0]} : ALT;
            primed_nx = 1'b1;
          end
          M_TGL:   seg_nx = {HW{~seg[0]}};
          default: seg_nx = seg;
        endcase
      end
    end

    if (LATE) begin : g_fall
      always_ff @(negedge clk) begin
        seg    <= seg_nx;
        primed <= primed_nx;
      end
    end else begin : g_rise
      always_ff @(posedge clk) begin
        seg    <= seg_nx;
        primed <= primed_nx;
      end
    end

    assign bank[h*HW +: HW] = seg;
  end

  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    logic [CNTW-1:0] c;
    always_ff @(posedge clk) begin
      if (rst) c <= CNTW'(k);
      else if (clk_en && mode_q == M_CNT) c <= c + 1'b1;
    end
    assign cnt_flat[k*CNTW +: CNTW] = c;
  end

  assign pins   = !out_en ? '0 : (mode_q == M_CNT ? cnt_flat[NBITS-1:0] : bank);
  assign parity = ^{bank, cnt_flat};
endmodule

// File: rtl/sw_stress_gen_chk.sv
module sw_stress_gen_chk #(
  parameter int NBITS = 16,
  parameter int NCNT  = 4,
  parameter int CNTW  = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 clk_en,
  input logic [1:0]           mode_q,
  input logic [NBITS-1:0]     bank,
  input logic [NCNT*CNTW-1:0] cnt_flat
);
  AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(bank) && $stable(cnt_flat))); // R5
  AST_TOGGLE_UNIFORM: assert property (@(posedge clk) disable iff (rst)
    mode_q == 2'b10 |-> (bank == '0 || bank == '1)); // R3
  AST_CHECKER_ALT: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b01 && bank != '0) |-> &(bank[NBITS-1:1] ^ bank[NBITS-2:0])); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    mode_q == 2'b00 |=> (bank == '0 && $stable(cnt_flat))); // R6
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(mode_q)); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (clk_en && mode_q == 2'b11) |=>
      cnt_flat[CNTW-1:0] == $past(cnt_flat[CNTW-1:0]) + 1'b1); // R4
endmodule

bind sw_stress_gen sw_stress_gen_chk #(.NBITS(NBITS), .NCNT(NCNT), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst(rst), .clk_en(clk_en), .mode_q(mode_q), .bank(bank), .cnt_flat(cnt_flat)
);

// File: tb/test_sw_stress_gen.sv
`timescale 1ns/1ps
module test_sw_stress_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic clk_en = 1'b0, out_en = 1'b1;
  logic [15:0] pins;
  logic parity;
  int checks = 0, failures = 0;

  logic [15:0] eb;
  logic        primed;
  logic [31:0] ec [4];
  logic [1:0]  em;

  sw_stress_gen i_sw_stress_gen (.clk(clk), .rst(rst), .mode(mode), .clk_en(clk_en),
    .out_en(out_en), .pins(pins), .parity(parity));

  always #2 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #3;
  endtask

  function automatic logic exp_par();
    return ^eb ^ (^ec[0]) ^ (^ec[1]) ^ (^ec[2]) ^ (^ec[3]);
  endfunction

  function automatic string mtag(logic [1:0] m);
    case (m)
      2'b01: return "R2 R7";
      2'b10: return "R3 R7";
      2'b11: return "R4 R7";
      default: return "R6 R7";
    endcase
  endfunction

  task automatic do_reset(logic [1:0] m);
    rst = 1'b1; mode = m; clk_en = 1'b1; out_en = 1'b1;
    tick(); tick(); tick();
    check("R1 pins", {16'h0, pins}, 32'h0);
    check("R1 parity", {31'h0, parity}, 32'h0);
    eb = '0; primed = 1'b0; em = m;
    for (int k = 0; k < 4; k++) ec[k] = k;
    rst = 1'b0;
    mode = m + 2'd1;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int m = 0; m < 4; m++) begin
      do_reset(2'(m));
      for (int c = 0; c < 40; c++) begin
        logic en_now, oe_now;
        logic [15:0] ep;
        string tag;
        en_now = (c % 5) != 3;
        oe_now = (c % 7) < 5;
        clk_en = en_now; out_en = oe_now;
        tick();
        if (en_now) begin
          case (em)
            2'b01: begin
              eb = primed ? {eb[14:0], ~eb[0]} : 16'h5555;
              primed = 1'b1;
            end
            2'b10: eb = {16{~eb[0]}};
            2'b11: for (int k = 0; k < 4; k++) ec[k] = ec[k] + 1;
            default: ;
          endcase
        end
        ep = !oe_now ? 16'h0 : (em == 2'b11 ? ec[0][15:0] : eb);
        tag = !oe_now ? "R8" : (!en_now ? "R5" : mtag(em));
        check(tag, {16'h0, pins}, {16'h0, ep});
        check("R9", {31'h0, parity}, {31'h0, exp_par()});
        mode = 2'(c);
      end
    end
    rst = 1'b1; mode = 2'b10; clk_en = 1'b1; out_en = 1'b1;
    tick(); tick();
    rst = 1'b0;
    @(posedge clk); #1;
    check("R10 early", {16'h0, pins}, 32'h0000_00FF);
    #2;
    check("R10 late", {16'h0, pins}, 32'h0000_FFFF);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule